// File: doc/BRIEF.md
# Partial-Replica Timing Error Detector

This block wraps a timing-critical multiply-add, `a*b + c`, and splits it into a front section (the multiply) and a back section (the add). The main path evaluates both sections in a single cycle. The multiplier product and the addend are registered. A second copy of the back section, and only that section, then evaluates again from those registers in the following cycle. Its timing is relaxed because it starts from flops and not from the primary operands. The main-path result is delayed by one register so that the two results line up, and they are compared in that second cycle.

A mismatch is treated as a timing fault. The block raises `retry` and runs a fixed recovery order. First it switches its internal clock enable from every cycle to every other cycle. Then it flushes the pending stage. Then it reissues the failed operation from its stored operands. Slow mode lasts for a number of committed results set on `hold_ops`, and full speed then resumes. Operations enter through a valid/ready handshake that stalls during recovery. Faults are created through a test input that flips one bit of the main-path result for a newly accepted operation.

Top module: `ptd_top`

## Requirements
- R1: At full speed, an operation accepted at a clock edge (`in_valid` and `in_ready` both high) presents `out_valid` high with `out_data = (in_a*in_b + in_c) mod 2^(2W)` in the cycle after that edge. Back-to-back operations are accepted every cycle.
- R2: An operation accepted with `inject` low never causes `retry`, and it leaves `err_count` unchanged.
- R3: When `inject` is high at an accepting edge, bit `inj_bit` of that operation's main-path result is inverted. In the comparison cycle `retry` goes high and `out_valid` stays low, so the corrupted value is never presented.
- R4: `rec_phase` encodes 0 = run, 1 = step-down, 2 = flush, 3 = reissue. After a `retry` cycle it moves 0→1→2→3→0, with step-down and flush lasting one cycle each. No other transition occurs.
- R5: `in_ready` is low whenever `rec_phase` is not 0. A failed operation's correct result is delivered before the result of any later operation, and no result is lost or repeated.
- R6: `slow_mode` rises in the cycle after step-down. While it is high, `in_ready` and `out_valid` are never high in two consecutive cycles.
- R7: Slow mode lasts until `hold_ops` results have been committed, with a value of 0 treated as 1. `slow_mode` falls in the cycle after the last of those commits.
- R8: `err_count` increments by one on each `retry` cycle and saturates at 2^ECW-1.
- R9: After reset, `out_valid`, `retry`, `slow_mode` and `recovering` are low, `in_ready` is high, and `rec_phase` and `err_count` are 0.
- R10: `inject` has no effect in a cycle where no operation is accepted, including the whole of a recovery. It never corrupts a reissued operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation taken at this edge if valid |
| in_a | input | W | Multiplicand |
| in_b | input | W | Multiplier |
| in_c | input | 2W | Addend |
| inject | input | 1 | Flip one main-path result bit of the accepted operation |
| inj_bit | input | clog2(2W) | Bit position to flip |
| hold_ops | input | HW | Committed results to stay in slow mode |
| out_valid | output | 1 | Checked result available |
| out_data | output | 2W | Checked result |
| retry | output | 1 | Mismatch detected this cycle |
| rec_phase | output | 2 | Recovery phase |
| slow_mode | output | 1 | Clock enable at half rate |
| recovering | output | 1 | Phase is not run |
| err_count | output | ECW | Saturating mismatch count |

## Verification
The bench sweeps every multiplicand and multiplier pair at full speed. A wrong front/back split, or a delay register that is misaligned, would show up there either as wrong sums or as spurious retries. It injects a fault at every result bit position. A comparator that does not cover the whole result would miss the top or bottom bit. After each fault the bench follows the phase order and the ordering of results. A recovery that reissued before flushing, or lost the failed operation, would duplicate or drop a result. It also counts committed results in slow mode for several `hold_ops` values, including zero, and it holds `inject` high while idle and during recovery to catch a reissue that picks up the fault. The bench drives the error counter past its limit to confirm that it saturates.

// File: rtl/ptd_pkg.sv
package ptd_pkg;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_STEP    = 2'd1,
        PH_FLUSH   = 2'd2,
        PH_REISSUE = 2'd3
    } rec_phase_e;

    // Recovery advances strictly in order: step-down, flush, reissue, run.
    function automatic rec_phase_e next_phase(input rec_phase_e p);
        case (p)
            PH_RUN:   return PH_STEP;
            PH_STEP:  return PH_FLUSH;
            PH_FLUSH: return PH_REISSUE;
            default:  return PH_RUN;
        endcase
    endfunction

endpackage

// File: rtl/mac_front.sv
module mac_front #(
    parameter int W = 8,
    localparam int RW = 2 * W
) (
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [RW-1:0] prod
);
    assign prod = RW'(a) * RW'(b);
endmodule

// File: rtl/mac_back.sv
module mac_back #(
    parameter int W = 8,
    localparam int RW = 2 * W
) (
    input  logic [RW-1:0] prod,
    input  logic [RW-1:0] addend,
    output logic [RW-1:0] sum
);
    assign sum = prod + addend;
endmodule

// File: rtl/ptd_recovery.sv
module ptd_recovery
    import ptd_pkg::*;
#(
    parameter int HW  = 4,
    parameter int ECW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            mismatch,
    input  logic            commit,
    input  logic [HW-1:0]   hold_ops,
    output rec_phase_e      phase,
    output logic            ce,
    output logic            slow,
    output logic [ECW-1:0]  err_cnt
);
    localparam logic [ECW-1:0] ERR_MAX = {ECW{1'b1}};

    rec_phase_e     phase_q;
    logic           slow_q;
    logic           div_ph_q;
    logic [HW-1:0]  left_q;
    logic [ECW-1:0] err_q;

    assign phase   = phase_q;
    assign slow    = slow_q;
    assign err_cnt = err_q;
    assign ce      = !slow_q || div_ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_RUN;
            slow_q   <= 1'b0;
            div_ph_q <= 1'b0;
            left_q   <= '0;
            err_q    <= '0;
        end else begin
            div_ph_q <= slow_q ? !div_ph_q : 1'b0;
            case (phase_q)
                PH_RUN: begin
                    if (mismatch) begin
                        phase_q <= next_phase(phase_q);
                        if (err_q != ERR_MAX) err_q <= err_q + 1'b1;
                    end else if (commit && slow_q) begin
                        if (left_q < HW'(2)) slow_q <= 1'b0;
                        else                 left_q <= left_q - 1'b1;
                    end
                end
                PH_STEP: begin
                    slow_q  <= 1'b1;
                    left_q  <= hold_ops;
                    phase_q <= next_phase(phase_q);
                end
                PH_FLUSH: begin
                    div_ph_q <= 1'b0;
                    phase_q  <= next_phase(phase_q);
                end
                default: begin
                    if (ce) phase_q <= next_phase(phase_q);
                end
            endcase
        end
    end

    AST_RETRY_STEP: assert property (@(posedge clk) disable iff (rst)
        mismatch && phase_q == PH_RUN |=> phase_q == PH_STEP); // R4
    AST_STEP_FLUSH: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_STEP |=> phase_q == PH_FLUSH && slow_q); // R4
    AST_FLUSH_REISSUE: assert property (@(posedge clk) disable iff (rst)
        phase_q == PH_FLUSH |=> phase_q == PH_REISSUE); // R4
    AST_SLOW_GAP: assert property (@(posedge clk) disable iff (rst)
        slow_q && ce |=> !ce || !slow_q); // R6
    AST_ERR_INC: assert property (@(posedge clk) disable iff (rst)
        mismatch && phase_q == PH_RUN && err_q != ERR_MAX |=> err_q == $past(err_q) + 1'b1); // R8
    AST_ERR_SAT: assert property (@(posedge clk) disable iff (rst)
        err_q == ERR_MAX |=> err_q == ERR_MAX); // R8

endmodule

// File: rtl/ptd_top.sv
module ptd_top
    import ptd_pkg::*;
#(
    parameter int W   = 8,
    parameter int HW  = 4,
    parameter int ECW = 8,
    localparam int RW  = 2 * W,
    localparam int IBW = $clog2(RW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic [W-1:0]    in_a,
    input  logic [W-1:0]    in_b,
    input  logic [RW-1:0]   in_c,
    input  logic            inject,
    input  logic [IBW-1:0]  inj_bit,
    input  logic [HW-1:0]   hold_ops,
    output logic            out_valid,
    output logic [RW-1:0]   out_data,
    output logic            retry,
    output logic [1:0]      rec_phase,
    output logic            slow_mode,
    output logic            recovering,
    output logic [ECW-1:0]  err_count
);
    typedef struct packed {
        logic [W-1:0]  a;
        logic [W-1:0]  b;
        logic [RW-1:0] c;
    } op_t;

    op_t            op_q, op_sel;
    logic           v_q;
    logic [RW-1:0]  front_q;    // registered front-section output
    logic [RW-1:0]  main_q;     // main result, delayed one stage
    logic [RW-1:0]  prod_m, sum_m, sum_d, flip;
    rec_phase_e     phase;
    logic           ce, slow, run, differ, mismatch, commit, accept, reissue_go;

    assign run        = (phase == PH_RUN);
    assign differ     = (sum_d != main_q);
    assign mismatch   = v_q && ce && run && differ;
    assign commit     = v_q && ce && run && !differ;
    assign in_ready   = run && ce && !mismatch;
    assign accept     = in_valid && in_ready;
    assign reissue_go = (phase == PH_REISSUE) && ce;
    assign op_sel     = reissue_go ? op_q : op_t'{a: in_a, b: in_b, c: in_c};
    assign flip       = (accept && inject) ? (RW'(1) << inj_bit) : '0;

    // Main path: front and back in one cycle.
    mac_front #(.W(W)) u_front  (.a(op_sel.a), .b(op_sel.b), .prod(prod_m));
    mac_back  #(.W(W)) u_back_m (.prod(prod_m), .addend(op_sel.c), .sum(sum_m));
    // Replica of the back section only, fed from registered front output.
    mac_back  #(.W(W)) u_back_d (.prod(front_q), .addend(op_q.c), .sum(sum_d));

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= 1'b0;
        end else if (phase == PH_FLUSH) begin
            v_q <= 1'b0;
        end else if (reissue_go || (run && ce && accept)) begin
            v_q     <= 1'b1;
            op_q    <= op_sel;
            front_q <= prod_m;
            main_q  <= sum_m ^ flip;
        end else if (run && ce) begin
            v_q <= mismatch;
        end
    end

    ptd_recovery #(.HW(HW), .ECW(ECW)) u_rec (
        .clk      (clk),
        .rst      (rst),
        .mismatch (mismatch),
        .commit   (commit),
        .hold_ops (hold_ops),
        .phase    (phase),
        .ce       (ce),
        .slow     (slow),
        .err_cnt  (err_count)
    );

    assign out_valid  = commit;
    assign out_data   = main_q;
    assign retry      = mismatch;
    assign rec_phase  = phase;
    assign slow_mode  = slow;
    assign recovering = !run;

    AST_READY_RUN: assert property (@(posedge clk) disable iff (rst)
        phase != PH_RUN |-> !in_ready); // R5
    AST_KEEP_OPERAND: assert property (@(posedge clk) disable iff (rst)
        retry |=> $stable(op_q)); // R5
    AST_RETRY_SILENT: assert property (@(posedge clk) disable iff (rst)
        retry |-> !out_valid); // R3
    AST_REISSUE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        reissue_go |=> main_q == sum_d); // R10

endmodule

// File: tb/ptd_top_bench.sv
module ptd_top_bench;
    localparam int W = 4, HW = 4, ECW = 3, RW = 2 * W, IBW = $clog2(RW);

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, inject = 1'b0;
    logic [W-1:0] in_a = '0, in_b = '0;
    logic [RW-1:0] in_c = '0;
    logic [IBW-1:0] inj_bit = '0;
    logic [HW-1:0] hold_ops = 4'd2;
    logic in_ready, out_valid, retry, slow_mode, recovering;
    logic [RW-1:0] out_data;
    logic [1:0] rec_phase;
    logic [ECW-1:0] err_count;

    int checks = 0, errors = 0, retries = 0, slow_commits = 0, cyc = 0;
    bit done = 0, seen1 = 0, seen2 = 0, seen3 = 0;
    logic [RW-1:0] exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    ptd_top #(.W(W), .HW(HW), .ECW(ECW)) u_ptd_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_a(in_a), .in_b(in_b), .in_c(in_c), .inject(inject), .inj_bit(inj_bit),
        .hold_ops(hold_ops), .out_valid(out_valid), .out_data(out_data),
        .retry(retry), .rec_phase(rec_phase), .slow_mode(slow_mode),
        .recovering(recovering), .err_count(err_count));

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: sampled at the falling edge, away from the active edge.
    logic [1:0] prev_ph = 2'd0;
    bit prev_retry = 0, prev_rdy_slow = 0, prev_out_slow = 0;
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) chk(0, "R5 unexpected result", out_data, 0);
                else begin
                    logic [RW-1:0] e;
                    e = exp_q.pop_front();
                    chk(out_data == e, "R1 result value/order", out_data, e);
                end
                if (slow_mode) slow_commits++;
            end
            if (retry) begin
                retries++;
                slow_commits = 0;
                chk(!out_valid, "R3 output suppressed on retry", out_valid, 0);
            end
            if (rec_phase != prev_ph) begin
                chk((prev_ph == 0 && rec_phase == 1 && prev_retry) ||
                    (prev_ph == 1 && rec_phase == 2) || (prev_ph == 2 && rec_phase == 3) ||
                    (prev_ph == 3 && rec_phase == 0), "R4 phase transition", rec_phase, prev_ph + 1);
                if (rec_phase == 1) seen1 = 1;
                if (rec_phase == 2) begin seen2 = 1; chk(slow_mode, "R6 slow after step-down", slow_mode, 1); end
                if (rec_phase == 3) seen3 = 1;
            end
            if (rec_phase != 0 && in_ready) chk(0, "R5 ready during recovery", in_ready, 0);
            if (slow_mode && in_ready && prev_rdy_slow) chk(0, "R6 consecutive ready in slow", 1, 0);
            if (slow_mode && out_valid && prev_out_slow) chk(0, "R6 consecutive out in slow", 1, 0);
            prev_rdy_slow = slow_mode && in_ready;
            prev_out_slow = slow_mode && out_valid;
            prev_ph = rec_phase;
            prev_retry = retry;
        end
    end

    task automatic send(input int a, input int b, input int c, input bit inj, input int bitpos);
        @(negedge clk);
        in_valid = 1; in_a = W'(a); in_b = W'(b); in_c = RW'(c);
        inject = inj; inj_bit = IBW'(bitpos);
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        exp_q.push_back(RW'(a * b + c));
    endtask

    task automatic idle(input int n, input bit inj);
        @(negedge clk);
        in_valid = 0; inject = inj; inj_bit = IBW'(5);
        repeat (n) @(negedge clk);
        inject = 0;
    endtask

    task automatic drain();
        idle(1, 0);
        for (int i = 0; i < 60 && (exp_q.size() != 0 || rec_phase != 0); i++) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R5 all results delivered", exp_q.size(), 0);
    endtask

    task automatic fault_run(input int hold, input int follow, input int bitpos, input int exp_slow);
        int r0;
        r0 = retries;
        hold_ops = HW'(hold);
        seen1 = 0; seen2 = 0; seen3 = 0;
        send(5, 6, 7 + bitpos, 1, bitpos);
        for (int k = 0; k < follow; k++) send(k + 1, 15 - k, 3 * k, 0, 0);
        drain();
        chk(retries == r0 + 1, "R3 one retry per fault", retries - r0, 1);
        chk(seen1 && seen2 && seen3, "R4 all phases visited", {seen1, seen2, seen3}, 7);
        chk(slow_commits == exp_slow, "R7 slow-mode commit count", slow_commits, exp_slow);
        chk(!slow_mode, "R7 full speed resumed", slow_mode, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R9 reset state
        chk(!out_valid && !retry && !slow_mode && !recovering, "R9 outputs low", out_valid, 0);
        chk(in_ready, "R9 ready high", in_ready, 1);
        chk(rec_phase == 0 && err_count == 0, "R9 phase/count zero", err_count, 0);

        // R1 one-cycle latency
        send(3, 5, 10, 0, 0);
        @(negedge clk); in_valid = 0; #1;
        chk(out_valid && out_data == RW'(25), "R1 latency", out_data, 25);
        drain();

        // R1 R2 exhaustive sweep, back to back
        begin
            int c0;
            c0 = cyc;
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    send(a, b, (a * 37 + b * 11) % 256, 0, 0);
            drain();
            chk(cyc - c0 <= 256 + 70, "R1 full-rate acceptance", cyc - c0, 256);
        end
        chk(retries == 0, "R2 no retry without fault", retries, 0);
        chk(err_count == 0, "R2 error count unchanged", err_count, 0);

        // R10 inject while idle
        idle(8, 1);
        send(7, 9, 1, 0, 0);
        drain();
        chk(retries == 0, "R10 idle inject ignored", retries, 0);

        // R3 R4 R7 R8 faults with several hold values
        fault_run(2, 3, 3, 2);
        chk(err_count == 1, "R8 count increments", err_count, 1);
        fault_run(0, 2, 0, 1);
        fault_run(5, 6, 7, 5);
        chk(err_count == 3, "R8 count after three", err_count, 3);

        // R10 inject held through recovery must not hit the reissue
        hold_ops = 4'd1;
        send(2, 2, 2, 1, 4);
        idle(14, 1);
        drain();
        chk(retries == 4, "R10 reissue not corrupted", retries, 4);

        // R3 every bit position; R8 saturation
        for (int bp = 0; bp < RW; bp++) fault_run(1, 1, bp, 1);
        chk(err_count == 3'd7, "R8 saturation", err_count, 7);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            chk(0, "R5 watchdog expired", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule